// File: doc/BRIEF.md
# Byte-Capacity Serial Data FIFO with Level Thresholds

This block is the data queue that sits between a register bus and a serial shift engine. It holds a fixed 256 bytes. Software chooses at run time whether each entry is one byte, a 16-bit word or a 32-bit word, so the number of entries the queue can hold is 256 divided by the entry size in bytes. Data enters through a valid/ready push stream and leaves through a valid/ready pop stream. Both streams carry 32-bit words, and only the low bits that belong to the entry are kept.

A plain operation input resets the queue and starts or stops it. A status word reports the fill level together with full and empty. The block also reports two kinds of threshold result. The first is an 8-bit threshold counted in entries. The second is a set of three 6-bit check points counted in 4-byte units. Software or the shift engine uses these results to decide when to refill or drain the queue. When a push meets a full queue, the block raises a one-cycle overflow pulse. When a pop meets an empty queue, it raises a one-cycle underflow pulse.

The push stream applies back-pressure by holding push_ready low while the queue is stopped or full. A word transfers on a rising edge where push_valid and push_ready are both high. The pop stream offers the oldest entry on pop_data with pop_valid high while the queue is running and not empty. An entry leaves on a rising edge where pop_valid and pop_ready are both high. A producer may hold push_valid while push_ready is low, and a consumer may hold pop_ready while pop_valid is low.

Top module: `sfifo_lvl`

## Requirements
- R1: status[8] is high exactly when the queue holds 256 bytes, and status[9] is high exactly when it holds none. status[7:0] is the entry count modulo 256, so a full byte-wide queue reads 0 there with status[8] high.
- R2: cfg_ctrl[1:0] selects the entry width: 0 is byte, 1 is 16-bit and 2 or 3 is 32-bit. An entry is the low bits of push_data, and pops return entries in push order, zero-extended to 32 bits.
- R3: The entry width takes effect only at a reset operation, or at hardware reset, which selects byte width. Changing cfg_ctrl[1:0] at any other time has no effect on the queue.
- R4: A write with op_wr high acts on op_data as follows. op_data[0]=1 empties the queue and clears its pointers. op_data[1] sets the running state, so writing 0 stops the queue. While the queue is stopped, push_ready and pop_valid are low, the level is held, and no overflow or underflow pulse occurs.
- R5: push_ready is high exactly when the queue is running and not full. A word is accepted on an edge where push_valid and push_ready are both high.
- R6: pop_valid is high exactly when the queue is running and not empty. pop_data shows the oldest entry, or zero when the queue is empty.
- R7: ovf is high for one cycle, in the cycle after a cycle in which the queue was running and full and push_valid was high. The word is not accepted.
- R8: udf is high for one cycle, in the cycle after a cycle in which the queue was running and empty and pop_ready was high.
- R9: thr_hit is high when the entry count is greater than or equal to cfg_ctrl[9:2].
- R10: lc_hit[0], lc_hit[1] and lc_hit[2] are high when the byte count divided by 4 is greater than or equal to lvl_chk[5:0] (low-side point), lvl_chk[15:10] (middle point) and lvl_chk[25:20] (high-side point) respectively.
- R11: A push and a pop accepted on the same edge both take effect, and the level is unchanged.
- R12: After hardware reset the queue is stopped and empty, the width is byte, and ovf and udf are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ctrl | input | 10 | [1:0] entry width code, [9:2] entry threshold |
| lvl_chk | input | 26 | Three 6-bit check points at [5:0], [15:10], [25:20] |
| op_wr | input | 1 | Operation write strobe |
| op_data | input | 2 | [0] reset queue, [1] run |
| push_valid | input | 1 | Push stream valid |
| push_ready | output | 1 | Push stream ready |
| push_data | input | 32 | Push stream word |
| pop_valid | output | 1 | Pop stream valid |
| pop_ready | input | 1 | Pop stream ready |
| pop_data | output | 32 | Oldest entry, zero-extended |
| status | output | 10 | [7:0] entry count, [8] full, [9] empty |
| thr_hit | output | 1 | Entry threshold reached |
| lc_hit | output | 3 | Check-point results: low, middle, high |
| ovf | output | 1 | Overflow pulse |
| udf | output | 1 | Underflow pulse |

## Verification
push_ready, pop_valid and pop_data follow the current state in the same cycle. The bench therefore checks them just before the edge that would transfer a word. status, thr_hit and lc_hit change on the edge that accepts a push, a pop or an operation, and ovf and udf rise on the edge after the offending request. The bench drives every input at a falling edge and checks all these results at the next falling edge, against a byte-count model and an entry queue that it keeps itself. Each entry width is swept from empty to full and back to empty, with an overflow and an underflow attempted at each end.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  localparam int N_CHK      = 3;
  localparam int CHK_STRIDE = 10;

  typedef enum logic [1:0] {
    EW_BYTE = 2'd0,
    EW_HALF = 2'd1,
    EW_WORD = 2'd2,
    EW_ALT  = 2'd3
  } ew_e;

  // log2 of the entry size in bytes for a width code
  function automatic logic [1:0] ew_shift(input logic [1:0] code);
    case (ew_e'(code))
      EW_BYTE: return 2'd0;
      EW_HALF: return 2'd1;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/sfifo_ctl.sv
module sfifo_ctl #(
  parameter int BYTES = 256,
  localparam int AW = $clog2(BYTES),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_width,
  input  logic          op_wr,
  input  logic [1:0]    op_data,
  input  logic          push_valid,
  input  logic          pop_ready,
  output logic          push_ready,
  output logic          pop_valid,
  output logic          push_fire,
  output logic          run,
  output logic          empty,
  output logic          full,
  output logic [1:0]    shift,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] cnt,
  output logic          ovf,
  output logic          udf
);
  import sfifo_pkg::*;

  logic          pop_fire;
  logic [CW-1:0] nb;

  assign nb         = CW'(1) << shift;
  assign full       = (cnt == CW'(BYTES));
  assign empty      = (cnt == '0);
  assign push_ready = run && !full;
  assign pop_valid  = run && !empty;
  assign push_fire  = push_valid && push_ready;
  assign pop_fire   = pop_ready && pop_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      shift  <= 2'd0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      ovf    <= 1'b0;
      udf    <= 1'b0;
    end else begin
      ovf <= run && push_valid && full;
      udf <= run && pop_ready && empty;
      if (op_wr) run <= op_data[1];
      if (op_wr && op_data[0]) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
        cnt    <= '0;
        shift  <= ew_shift(cfg_width);
      end else begin
        if (push_fire) wr_ptr <= wr_ptr + nb[AW-1:0];
        if (pop_fire)  rd_ptr <= rd_ptr + nb[AW-1:0];
        cnt <= cnt + (push_fire ? nb : '0) - (pop_fire ? nb : '0);
      end
    end
  end
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int BYTES = 256,
  parameter int DW    = 32,
  localparam int AW    = $clog2(BYTES),
  localparam int LANES = DW / 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [1:0]    shift,
  input  logic          empty,
  input  logic [AW-1:0] wr_ptr,
  input  logic [AW-1:0] rd_ptr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [7:0] mem [BYTES];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int k = 0; k < LANES; k++) begin
        if (k < (1 << shift)) mem[wr_ptr + AW'(k)] <= wdata[8*k +: 8];
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rdata[8*g +: 8] = (!empty && (g < (1 << shift))) ?
                             mem[rd_ptr + AW'(g)] : 8'h00;
  end
endmodule

// File: rtl/sfifo_thresh.sv
module sfifo_thresh #(
  parameter int BYTES   = 256,
  parameter int THR_W   = 8,
  parameter int PT_W    = 6,
  parameter int STAT_LW = 8,
  localparam int CW    = $clog2(BYTES) + 1,
  localparam int CHK_W = (sfifo_pkg::N_CHK - 1) * sfifo_pkg::CHK_STRIDE + PT_W
) (
  input  logic [CW-1:0]              cnt,
  input  logic [1:0]                 shift,
  input  logic [THR_W-1:0]           thr,
  input  logic [CHK_W-1:0]           chk,
  output logic [STAT_LW-1:0]         lvl_field,
  output logic                       thr_hit,
  output logic [sfifo_pkg::N_CHK-1:0] lc_hit
);
  import sfifo_pkg::*;

  logic [CW-1:0] entries;
  logic [CW-1:0] units;

  assign entries   = cnt >> shift;
  assign units     = cnt >> 2;
  assign lvl_field = entries[STAT_LW-1:0];
  assign thr_hit   = entries >= CW'(thr);

  for (genvar i = 0; i < N_CHK; i++) begin : g_chk
    assign lc_hit[i] = units >= CW'(chk[i*CHK_STRIDE +: PT_W]);
  end
endmodule

// File: rtl/sfifo_lvl.sv
module sfifo_lvl #(
  parameter int BYTES   = 256,
  parameter int DW      = 32,
  parameter int THR_W   = 8,
  parameter int PT_W    = 6,
  parameter int STAT_LW = 8,
  localparam int AW    = $clog2(BYTES),
  localparam int CW    = AW + 1,
  localparam int CHK_W = (sfifo_pkg::N_CHK - 1) * sfifo_pkg::CHK_STRIDE + PT_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [THR_W+1:0]           cfg_ctrl,
  input  logic [CHK_W-1:0]           lvl_chk,
  input  logic                       op_wr,
  input  logic [1:0]                 op_data,
  input  logic                       push_valid,
  output logic                       push_ready,
  input  logic [DW-1:0]              push_data,
  output logic                       pop_valid,
  input  logic                       pop_ready,
  output logic [DW-1:0]              pop_data,
  output logic [STAT_LW+1:0]         status,
  output logic                       thr_hit,
  output logic [sfifo_pkg::N_CHK-1:0] lc_hit,
  output logic                       ovf,
  output logic                       udf
);
  logic               run_q;
  logic               empty;
  logic               full;
  logic               push_fire;
  logic [1:0]         shift;
  logic [AW-1:0]      wr_ptr;
  logic [AW-1:0]      rd_ptr;
  logic [CW-1:0]      cnt;
  logic [STAT_LW-1:0] lvl_field;

  sfifo_ctl #(.BYTES(BYTES)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_width  (cfg_ctrl[1:0]),
    .op_wr      (op_wr),
    .op_data    (op_data),
    .push_valid (push_valid),
    .pop_ready  (pop_ready),
    .push_ready (push_ready),
    .pop_valid  (pop_valid),
    .push_fire  (push_fire),
    .run        (run_q),
    .empty      (empty),
    .full       (full),
    .shift      (shift),
    .wr_ptr     (wr_ptr),
    .rd_ptr     (rd_ptr),
    .cnt        (cnt),
    .ovf        (ovf),
    .udf        (udf)
  );

  sfifo_store #(.BYTES(BYTES), .DW(DW)) u_store (
    .clk    (clk),
    .we     (push_fire),
    .shift  (shift),
    .empty  (empty),
    .wr_ptr (wr_ptr),
    .rd_ptr (rd_ptr),
    .wdata  (push_data),
    .rdata  (pop_data)
  );

  sfifo_thresh #(.BYTES(BYTES), .THR_W(THR_W), .PT_W(PT_W), .STAT_LW(STAT_LW)) u_thr (
    .cnt       (cnt),
    .shift     (shift),
    .thr       (cfg_ctrl[THR_W+1:2]),
    .chk       (lvl_chk),
    .lvl_field (lvl_field),
    .thr_hit   (thr_hit),
    .lc_hit    (lc_hit)
  );

  assign status = {empty, full, lvl_field};
endmodule

// File: rtl/sfifo_lvl_chk.sv
module sfifo_lvl_chk #(
  parameter int DW = 32,
  parameter int SW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          op_wr,
  input logic [1:0]    op_data,
  input logic          push_valid,
  input logic          push_ready,
  input logic          pop_valid,
  input logic          pop_ready,
  input logic [DW-1:0] pop_data,
  input logic [SW-1:0] status,
  input logic          ovf,
  input logic          udf
);
  logic st_full, st_empty;
  assign st_full  = status[SW-2];
  assign st_empty = status[SW-1];

  AST_NOT_FULL_AND_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_full && st_empty)); // R1
  AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    st_full |-> !push_ready); // R5
  AST_EMPTY_POP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    st_empty |-> (!pop_valid && pop_data == '0)); // R6
  AST_OVF_ON_FULL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (run && push_valid && st_full) |=> ovf); // R7
  AST_UDF_ON_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pop_ready && st_empty) |=> udf); // R8
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !op_wr) |=> ($stable(status) && !ovf && !udf)); // R4
  AST_STOPPED_NO_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!push_ready && !pop_valid)); // R4
  AST_RESET_OP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (op_wr && op_data[0]) |=> st_empty); // R4
endmodule

bind sfifo_lvl sfifo_lvl_chk #(.DW(DW), .SW(STAT_LW + 2)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run_q),
  .op_wr      (op_wr),
  .op_data    (op_data),
  .push_valid (push_valid),
  .push_ready (push_ready),
  .pop_valid  (pop_valid),
  .pop_ready  (pop_ready),
  .pop_data   (pop_data),
  .status     (status),
  .ovf        (ovf),
  .udf        (udf)
);

// File: tb/tb_sfifo_lvl.sv
`timescale 1ns/1ps
module tb_sfifo_lvl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  cfg_ctrl = '0;
  logic [25:0] lvl_chk = '0;
  logic        op_wr = 1'b0;
  logic [1:0]  op_data = '0;
  logic        push_valid = 1'b0;
  logic        push_ready;
  logic [31:0] push_data = '0;
  logic        pop_valid;
  logic        pop_ready = 1'b0;
  logic [31:0] pop_data;
  logic [9:0]  status;
  logic        thr_hit;
  logic [2:0]  lc_hit;
  logic        ovf, udf;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  int          bcount = 0;
  int          bw = 1;
  bit          run = 0;
  logic [31:0] q[$];

  always #4 clk = ~clk;

  sfifo_lvl dut (
    .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl), .lvl_chk(lvl_chk),
    .op_wr(op_wr), .op_data(op_data),
    .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
    .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_data(pop_data),
    .status(status), .thr_hit(thr_hit), .lc_hit(lc_hit), .ovf(ovf), .udf(udf)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int bytes_of(input logic [1:0] code);
    return (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] msk(input logic [31:0] d);
    return (bw == 1) ? (d & 32'hFF) : (bw == 2) ? (d & 32'hFFFF) : d;
  endfunction

  function automatic logic [31:0] pat(input int i);
    return (32'h9E37_79B9 * (i + 1)) ^ (i << 3);
  endfunction

  task automatic check_levels(input string ctx);
    int ent = bcount / bw;
    int units = bcount / 4;
    logic [9:0] exp_st = {bcount == 0, bcount == 256, 8'(ent)};
    logic [2:0] exp_lc;
    exp_lc[0] = units >= int'(lvl_chk[5:0]);
    exp_lc[1] = units >= int'(lvl_chk[15:10]);
    exp_lc[2] = units >= int'(lvl_chk[25:20]);
    chk({ctx, " R1 status"}, 32'(status), 32'(exp_st));
    chk({ctx, " R9 thr_hit"}, 32'(thr_hit), 32'(ent >= int'(cfg_ctrl[9:2])));
    chk({ctx, " R10 lc_hit"}, 32'(lc_hit), 32'(exp_lc));
  endtask

  task automatic do_op(input logic [1:0] v);
    op_wr = 1'b1;
    op_data = v;
    tick();
    op_wr = 1'b0;
    run = v[1];
    if (v[0]) begin
      bcount = 0;
      q.delete();
      bw = bytes_of(cfg_ctrl[1:0]);
    end
  endtask

  // one cycle of stream activity, checked against the model
  task automatic step(input string ctx, input bit pv, input logic [31:0] pd, input bit pr);
    bit full_b = (bcount == 256);
    bit empty_b = (bcount == 0);
    bit exp_pr = run && !full_b;
    bit exp_pv = run && !empty_b;
    push_valid = pv;
    push_data = pd;
    pop_ready = pr;
    chk({ctx, " R5 push_ready"}, 32'(push_ready), 32'(exp_pr));
    chk({ctx, " R6 pop_valid"}, 32'(pop_valid), 32'(exp_pv));
    chk({ctx, " R2 pop_data"}, pop_data, empty_b ? 32'h0 : q[0]);
    tick();
    push_valid = 1'b0;
    pop_ready = 1'b0;
    if (pr && exp_pv) begin
      void'(q.pop_front());
      bcount -= bw;
    end
    if (pv && exp_pr) begin
      q.push_back(msk(pd));
      bcount += bw;
    end
    chk({ctx, " R7 ovf"}, 32'(ovf), 32'(run && pv && full_b));
    chk({ctx, " R8 udf"}, 32'(udf), 32'(run && pr && empty_b));
    check_levels(ctx);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cfg_ctrl = {8'd4, 2'd0};
    lvl_chk = {6'd9, 4'd0, 6'd5, 4'd0, 6'd1};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk("R12 status", 32'(status), 32'h200);
    chk("R12 push_ready", 32'(push_ready), 32'h0);
    chk("R12 pop_valid", 32'(pop_valid), 32'h0);
    chk("R12 ovf/udf", 32'({ovf, udf}), 32'h0);
    check_levels("R12");

    // sweep every entry width from empty to full to empty
    for (int w = 0; w < 3; w++) begin
      cfg_ctrl = {8'(5 + 40 * w), 2'(w)};
      lvl_chk = {6'd62, 4'd0, 6'(16 + 8 * w), 4'd0, 6'(2 + w)};
      do_op(2'b11);
      chk("R4 reset op empties", 32'(status[9]), 32'h1);
      check_levels("R4 after reset op");
      for (int i = 0; i < 256 / bw; i++) step("fill", 1'b1, pat(i + 300 * w), 1'b0);
      chk("R1 full flag at capacity", 32'(status[8]), 32'h1);
      step("overflow", 1'b1, 32'hDEAD_BEEF, 1'b0);
      step("after overflow", 1'b0, 32'h0, 1'b0);
      while (bcount > 0) step("drain", 1'b0, 32'h0, 1'b1);
      step("underflow", 1'b0, 32'h0, 1'b1);
      step("after underflow", 1'b0, 32'h0, 1'b0);
    end

    // R11 simultaneous push and pop, 16-bit entries
    cfg_ctrl = {8'd2, 2'd1};
    do_op(2'b11);
    for (int i = 0; i < 3; i++) step("R11 prefill", 1'b1, pat(900 + i), 1'b0);
    for (int i = 0; i < 6; i++) begin
      step("R11 push+pop", 1'b1, pat(910 + i), 1'b1);
      chk("R11 level unchanged", 32'(status[7:0]), 32'd3);
    end

    // R3 width change without reset op has no effect
    cfg_ctrl = {8'd1, 2'd2};
    do_op(2'b11);
    step("R3 push a", 1'b1, 32'h1122_3344, 1'b0);
    step("R3 push b", 1'b1, 32'h5566_7788, 1'b0);
    cfg_ctrl = {8'd1, 2'd0};
    step("R3 push c", 1'b1, 32'h99AA_BBCC, 1'b0);
    chk("R3 level still in 32-bit entries", 32'(status[7:0]), 32'd3);
    chk("R3 head keeps 32 bits", pop_data, 32'h1122_3344);
    step("R3 pop", 1'b0, 32'h0, 1'b1);
    do_op(2'b11);
    step("R3 byte push", 1'b1, 32'h0000_1234, 1'b0);
    chk("R3 byte width after reset op", pop_data, 32'h0000_0034);

    // R4 stop keeps contents and ignores traffic
    step("R4 push", 1'b1, 32'h0000_0056, 1'b0);
    do_op(2'b00);
    chk("R4 stopped push_ready", 32'(push_ready), 32'h0);
    chk("R4 stopped pop_valid", 32'(pop_valid), 32'h0);
    for (int i = 0; i < 3; i++) step("R4 stopped traffic", 1'b1, pat(i), 1'b1);
    chk("R4 level held while stopped", 32'(status[7:0]), 32'd2);
    do_op(2'b10);
    chk("R4 restart keeps data", pop_data, 32'h0000_0034);
    step("R4 pop after restart", 1'b0, 32'h0, 1'b1);
    step("R4 pop after restart", 1'b0, 32'h0, 1'b1);
    do_op(2'b01);
    chk("R4 reset-only leaves stopped", 32'(pop_valid), 32'h0);
    check_levels("R4 reset-only");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule